// File: doc/BRIEF.md
# Paged Memory Bank Mapper

This block sits between an 8-bit CPU with a 16-bit address bus and four kinds of physical memory: a boot ROM, two flash devices and a DRAM. The CPU space is cut into four equal windows by the top two address bits. Every window owns an 8-bit bank register, and that register's value decides which device and which 16 KB page the window reaches. The CPU can therefore see any page of any device through any window.

A bank value with its top bit set reaches DRAM. Subtracting 128 from the value gives the DRAM page. A value below 4 reaches the read-only boot pages. Any other value reaches one of the flash devices, and bit 6 chooses which one. The second flash is optional. A configuration input reports whether it is fitted. Pages of a missing device read as 0xFF and silently drop writes.

Software loads the bank registers through a small indexed register port and can read them back through the same port. After reset every register is zero, so the CPU starts running from boot page 0. Chip selects, the physical address, the write enable and the read data all follow the CPU strobes in the same cycle.

Top module: `bank_mapper`

## Requirements
- R1: The window is chosen by cpu_addr[15:14], and each window uses only its own bank register. The physical address carries cpu_addr[13:0] unchanged in bits 13:0.
- R2: When bit 7 of the selected bank value is 1, an access asserts dram_cs and mem_addr = ((bank − 128) << 14) | cpu_addr[13:0]. Both reads and writes are allowed.
- R3: When the selected bank value is 0 to 3, a read asserts rom_cs with mem_addr = (bank << 14) | offset. A write asserts no chip select and leaves mem_we low.
- R4: When the selected bank value is 4 to 127, bit 6 = 0 selects flash0 and bit 6 = 1 selects flash1. In both cases mem_addr = ((bank & 0x3F) << 14) | offset.
- R5: When flash1_present is 0, pages that would select flash1 have no memory. A read returns 0xFF, and no chip select or write enable is asserted.
- R6: While cpu_rd is 1 and cpu_wr is 0, cpu_rdata carries the data input of the selected device, or 0xFF when no device is selected. In every other cycle cpu_rdata is 0xFF.
- R7: Reset clears all four bank registers to 0x00, so window 0 reads boot page 0.
- R8: A register write with index reg_idx (0 to 3) is stored at the clock edge and takes effect from the next cycle. reg_rdata always shows the register that reg_idx points at.
- R9: At most one chip select is asserted at a time, and none without cpu_rd or cpu_wr. cpu_wr has priority over cpu_rd. mem_we is 1 only for a write to a flash or DRAM page.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| flash1_present | input | 1 | 1 when the second flash is fitted |
| cpu_addr | input | 16 | CPU address |
| cpu_rd | input | 1 | CPU read strobe |
| cpu_wr | input | 1 | CPU write strobe |
| cpu_rdata | output | 8 | Read data returned to the CPU |
| reg_wr | input | 1 | Bank register write strobe |
| reg_idx | input | 2 | Bank register index (window number) |
| reg_wdata | input | 8 | Bank register write value |
| reg_rdata | output | 8 | Bank register readback at reg_idx |
| rom_rdata | input | 8 | Boot ROM read data |
| flash0_rdata | input | 8 | First flash read data |
| flash1_rdata | input | 8 | Second flash read data |
| dram_rdata | input | 8 | DRAM read data |
| rom_cs | output | 1 | Boot ROM select |
| flash0_cs | output | 1 | First flash select |
| flash1_cs | output | 1 | Second flash select |
| dram_cs | output | 1 | DRAM select |
| mem_addr | output | 21 | Physical address: page in bits 20:14, offset in 13:0 |
| mem_we | output | 1 | Write enable for the selected device |

## Verification
The chip selects, mem_addr, mem_we, cpu_rdata and reg_rdata are combinational in the CPU inputs. They are due in the same cycle as the strobe, so the bench compares them at the falling edge that follows each input change. A register write appears only after the rising edge that stores it. The reference model updates its own bank copies at that same edge, so an access issued in the cycle after the write is checked against the new value, and an access issued in the cycle of the write is checked against the old one.

// File: rtl/bank_map_pkg.sv
package bank_map_pkg;
    typedef enum logic [2:0] {
        RGN_ROM    = 3'd0,
        RGN_FLASH0 = 3'd1,
        RGN_FLASH1 = 3'd2,
        RGN_DRAM   = 3'd3,
        RGN_NONE   = 3'd4
    } region_t;
endpackage

// File: rtl/bank_regfile.sv
module bank_regfile #(
    parameter int NWIN   = 4,
    parameter int IDX_W  = 2,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [IDX_W-1:0]  win_idx,
    output logic [DATA_W-1:0] rd_data,
    output logic [DATA_W-1:0] win_bank
);
    logic [NWIN-1:0][DATA_W-1:0] bank_q;

    for (genvar w = 0; w < NWIN; w++) begin : g_win
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                bank_q[w] <= '0;
            else if (wr_en && (wr_idx == IDX_W'(w)))
                bank_q[w] <= wr_data;
        end
    end

    assign rd_data  = bank_q[wr_idx];
    assign win_bank = bank_q[win_idx];
endmodule

// File: rtl/bank_decoder.sv
module bank_decoder
    import bank_map_pkg::*;
#(
    parameter int DATA_W    = 8,
    parameter int ROM_PAGES = 4,
    localparam int PAGE_W   = DATA_W - 1
) (
    input  logic [DATA_W-1:0] bank,
    input  logic              flash1_present,
    output region_t           region,
    output logic [PAGE_W-1:0] page
);
    logic dram_sel;
    logic chip_sel;

    assign dram_sel = bank[DATA_W-1];
    assign chip_sel = bank[DATA_W-2];

    always_comb begin
        if (dram_sel) begin
            region = RGN_DRAM;
            page   = bank[PAGE_W-1:0];
        end else begin
            page = {1'b0, bank[PAGE_W-2:0]};
            if (int'(bank) < ROM_PAGES)
                region = RGN_ROM;
            else if (!chip_sel)
                region = RGN_FLASH0;
            else if (flash1_present)
                region = RGN_FLASH1;
            else
                region = RGN_NONE;
        end
    end
endmodule

// File: rtl/bank_access.sv
module bank_access
    import bank_map_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  region_t           region,
    input  logic              rd,
    input  logic              wr,
    input  logic [DATA_W-1:0] rom_d,
    input  logic [DATA_W-1:0] fl0_d,
    input  logic [DATA_W-1:0] fl1_d,
    input  logic [DATA_W-1:0] dram_d,
    output logic [3:0]        cs,
    output logic              we,
    output logic [DATA_W-1:0] rdata
);
    logic rd_only;
    assign rd_only = rd && !wr;

    always_comb begin
        cs    = 4'b0000;
        we    = 1'b0;
        rdata = '1;
        if (rd || wr) begin
            unique case (region)
                RGN_ROM: begin
                    if (rd_only) begin
                        cs[0] = 1'b1;
                        rdata = rom_d;
                    end
                end
                RGN_FLASH0: begin
                    cs[1] = 1'b1;
                    we    = wr;
                    if (rd_only) rdata = fl0_d;
                end
                RGN_FLASH1: begin
                    cs[2] = 1'b1;
                    we    = wr;
                    if (rd_only) rdata = fl1_d;
                end
                RGN_DRAM: begin
                    cs[3] = 1'b1;
                    we    = wr;
                    if (rd_only) rdata = dram_d;
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/bank_mapper.sv
module bank_mapper
    import bank_map_pkg::*;
#(
    parameter int ADDR_W    = 16,
    parameter int WIN_BITS  = 2,
    parameter int DATA_W    = 8,
    parameter int ROM_PAGES = 4,
    localparam int OFF_W    = ADDR_W - WIN_BITS,
    localparam int NWIN     = 1 << WIN_BITS,
    localparam int PAGE_W   = DATA_W - 1,
    localparam int PHYS_W   = OFF_W + PAGE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flash1_present,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic              cpu_rd,
    input  logic              cpu_wr,
    output logic [DATA_W-1:0] cpu_rdata,
    input  logic              reg_wr,
    input  logic [WIN_BITS-1:0] reg_idx,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic [DATA_W-1:0] rom_rdata,
    input  logic [DATA_W-1:0] flash0_rdata,
    input  logic [DATA_W-1:0] flash1_rdata,
    input  logic [DATA_W-1:0] dram_rdata,
    output logic              rom_cs,
    output logic              flash0_cs,
    output logic              flash1_cs,
    output logic              dram_cs,
    output logic [PHYS_W-1:0] mem_addr,
    output logic              mem_we
);
    logic [DATA_W-1:0] sel_bank;
    logic [PAGE_W-1:0] page;
    region_t           region;
    logic [3:0]        cs;

    bank_regfile #(.NWIN(NWIN), .IDX_W(WIN_BITS), .DATA_W(DATA_W)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (reg_wr),
        .wr_idx   (reg_idx),
        .wr_data  (reg_wdata),
        .win_idx  (cpu_addr[ADDR_W-1:OFF_W]),
        .rd_data  (reg_rdata),
        .win_bank (sel_bank)
    );

    bank_decoder #(.DATA_W(DATA_W), .ROM_PAGES(ROM_PAGES)) u_dec (
        .bank           (sel_bank),
        .flash1_present (flash1_present),
        .region         (region),
        .page           (page)
    );

    bank_access #(.DATA_W(DATA_W)) u_acc (
        .region (region),
        .rd     (cpu_rd),
        .wr     (cpu_wr),
        .rom_d  (rom_rdata),
        .fl0_d  (flash0_rdata),
        .fl1_d  (flash1_rdata),
        .dram_d (dram_rdata),
        .cs     (cs),
        .we     (mem_we),
        .rdata  (cpu_rdata)
    );

    assign rom_cs    = cs[0];
    assign flash0_cs = cs[1];
    assign flash1_cs = cs[2];
    assign dram_cs   = cs[3];
    assign mem_addr  = {page, cpu_addr[OFF_W-1:0]};
endmodule

// File: rtl/bank_mapper_chk.sv
module bank_mapper_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        flash1_present,
    input logic [15:0] cpu_addr,
    input logic        cpu_rd,
    input logic        cpu_wr,
    input logic [7:0]  cpu_rdata,
    input logic        reg_wr,
    input logic [1:0]  reg_idx,
    input logic [7:0]  reg_wdata,
    input logic [7:0]  reg_rdata,
    input logic        rom_cs,
    input logic        flash0_cs,
    input logic        flash1_cs,
    input logic        dram_cs,
    input logic [20:0] mem_addr,
    input logic        mem_we
);
    assert_one_cs_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({rom_cs, flash0_cs, flash1_cs, dram_cs}));

    assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !(cpu_rd || cpu_wr) |-> !(rom_cs || flash0_cs || flash1_cs || dram_cs || mem_we));

    assert_we_needs_target_R9: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> (cpu_wr && (flash0_cs || flash1_cs || dram_cs)));

    assert_rom_read_only_R3: assert property (@(posedge clk) disable iff (!rst_n)
        rom_cs |-> (!mem_we && !cpu_wr && mem_addr[20:16] == 5'd0));

    assert_absent_flash_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !flash1_present |-> !flash1_cs);

    assert_offset_pass_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (rom_cs || flash0_cs || flash1_cs || dram_cs) |-> mem_addr[13:0] == cpu_addr[13:0]);

    assert_idle_rdata_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !cpu_rd |-> cpu_rdata == 8'hFF);

    assert_reset_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> reg_rdata == 8'h00);

    assert_reg_store_R8: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr |=> (reg_idx != $past(reg_idx) || reg_rdata == $past(reg_wdata)));
endmodule

bind bank_mapper bank_mapper_chk u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .flash1_present (flash1_present),
    .cpu_addr       (cpu_addr),
    .cpu_rd         (cpu_rd),
    .cpu_wr         (cpu_wr),
    .cpu_rdata      (cpu_rdata),
    .reg_wr         (reg_wr),
    .reg_idx        (reg_idx),
    .reg_wdata      (reg_wdata),
    .reg_rdata      (reg_rdata),
    .rom_cs         (rom_cs),
    .flash0_cs      (flash0_cs),
    .flash1_cs      (flash1_cs),
    .dram_cs        (dram_cs),
    .mem_addr       (mem_addr),
    .mem_we         (mem_we)
);

// File: tb/tb_bank_mapper.sv
module tb_bank_mapper;
    localparam int CLK_PERIOD = 10;

    logic        clk = 0;
    logic        rst_n = 0;
    logic        flash1_present = 1;
    logic [15:0] cpu_addr = 0;
    logic        cpu_rd = 0, cpu_wr = 0;
    logic [7:0]  cpu_rdata;
    logic        reg_wr = 0;
    logic [1:0]  reg_idx = 0;
    logic [7:0]  reg_wdata = 0;
    logic [7:0]  reg_rdata;
    logic [7:0]  rom_rdata = 8'hA1, flash0_rdata = 8'hB2, flash1_rdata = 8'hC3, dram_rdata = 8'hD4;
    logic        rom_cs, flash0_cs, flash1_cs, dram_cs, mem_we;
    logic [20:0] mem_addr;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    int model_bank [4];

    always #(CLK_PERIOD/2) clk = ~clk;

    bank_mapper dut (
        .clk(clk), .rst_n(rst_n), .flash1_present(flash1_present),
        .cpu_addr(cpu_addr), .cpu_rd(cpu_rd), .cpu_wr(cpu_wr), .cpu_rdata(cpu_rdata),
        .reg_wr(reg_wr), .reg_idx(reg_idx), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .rom_rdata(rom_rdata), .flash0_rdata(flash0_rdata), .flash1_rdata(flash1_rdata),
        .dram_rdata(dram_rdata), .rom_cs(rom_cs), .flash0_cs(flash0_cs),
        .flash1_cs(flash1_cs), .dram_cs(dram_cs), .mem_addr(mem_addr), .mem_we(mem_we)
    );

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < 4; i++) model_bank[i] <= 0;
        end else if (reg_wr) begin
            model_bank[reg_idx] <= int'(reg_wdata);
        end
    end

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s at %0t: actual %0h expected %0h", tag, $time, act, exp);
        end
    endtask

    // Reference: 0 rom, 1 flash0, 2 flash1, 3 dram, 4 none
    always @(negedge clk) begin
        if (rst_n) begin
            int b, kind, pg, expcs, expaddr, expwe, exprd;
            string tag;
            b = model_bank[cpu_addr[15:14]];
            if (b >= 128) begin kind = 3; pg = b - 128; end
            else if (b < 4) begin kind = 0; pg = b; end
            else if (b >= 64) begin kind = flash1_present ? 2 : 4; pg = b % 64; end
            else begin kind = 1; pg = b % 64; end
            expcs = 0; expwe = 0; exprd = 255;
            if (cpu_wr) begin
                if (kind == 1 || kind == 2 || kind == 3) begin
                    expcs = 1 << kind; expwe = 1;
                end
            end else if (cpu_rd) begin
                if (kind != 4) expcs = 1 << kind;
                case (kind)
                    0: exprd = rom_rdata;
                    1: exprd = flash0_rdata;
                    2: exprd = flash1_rdata;
                    3: exprd = dram_rdata;
                    default: exprd = 255;
                endcase
            end
            case (kind)
                0: tag = "R3 rom select";
                1, 2: tag = "R4 flash select";
                3: tag = "R2 dram select";
                default: tag = "R5 absent select";
            endcase
            if (!(cpu_rd || cpu_wr)) tag = "R9 idle select";
            check(tag, int'({dram_cs, flash1_cs, flash0_cs, rom_cs}), expcs);
            if (expcs != 0) begin
                expaddr = pg * 16384 + int'(cpu_addr[13:0]);
                check("R1 physical address", int'(mem_addr), expaddr);
            end
            check("R9 write enable", int'(mem_we), expwe);
            check("R6 read data", int'(cpu_rdata), exprd);
            check("R8 readback", int'(reg_rdata), model_bank[reg_idx]);
        end
    end

    task automatic cyc(input logic [15:0] a, input logic rd, input logic wr);
        cpu_addr = a; cpu_rd = rd; cpu_wr = wr;
        @(posedge clk); #1;
    endtask

    task automatic setbank(input logic [1:0] idx, input logic [7:0] v);
        reg_wr = 1; reg_idx = idx; reg_wdata = v;
        cpu_rd = 0; cpu_wr = 0;
        @(posedge clk); #1;
        reg_wr = 0;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        // R7: reset state, window 0 at boot page 0
        for (int i = 0; i < 4; i++) begin
            reg_idx = 2'(i); #1;
            check("R7 reset register", int'(reg_rdata), 0);
        end
        cpu_addr = 16'h0123; cpu_rd = 1; #1;
        check("R7 boot read rom_cs", int'(rom_cs), 1);
        check("R7 boot read addr", int'(mem_addr), 'h0123);
        @(posedge clk); #1;
        cyc(16'h0010, 0, 1);                 // ROM write dropped
        cyc(16'h0000, 0, 0);
        setbank(0, 8'h02); setbank(1, 8'h85); setbank(2, 8'h07); setbank(3, 8'h45);
        for (int w = 0; w < 4; w++) begin
            cyc({2'(w), 14'h1ABC}, 1, 0);
            cyc({2'(w), 14'h0F0F}, 0, 1);
            cyc({2'(w), 14'h3FFF}, 1, 1);
        end
        flash1_present = 0;
        cyc(16'hC055, 1, 0);
        cyc(16'hC056, 0, 1);
        flash1_present = 1;
        cyc(16'hC057, 1, 0);
        rom_rdata = 8'h5A; flash0_rdata = 8'h6B; flash1_rdata = 8'h7C; dram_rdata = 8'h8D;
        // boundary bank values
        setbank(1, 8'h03); cyc(16'h4001, 1, 0); cyc(16'h4001, 0, 1);
        setbank(1, 8'h04); cyc(16'h4002, 1, 0); cyc(16'h4002, 0, 1);
        setbank(1, 8'h3F); cyc(16'h7FFF, 1, 0);
        setbank(1, 8'h40); cyc(16'h4000, 1, 0);
        setbank(1, 8'h7F); cyc(16'h4AAA, 0, 1);
        setbank(1, 8'h80); cyc(16'h4333, 1, 0);
        setbank(1, 8'hFF); cyc(16'h7FFF, 0, 1);
        // write and access in the same cycle, then the next cycle
        reg_wr = 1; reg_idx = 2; reg_wdata = 8'h90; cpu_addr = 16'h8123; cpu_rd = 1;
        @(posedge clk); #1; reg_wr = 0;
        cyc(16'h8124, 1, 0);
        // window isolation: other windows unaffected
        cyc(16'h0500, 1, 0);
        cyc(16'hC500, 1, 0);
        for (int i = 0; i < 4; i++) begin
            reg_idx = 2'(i); cyc(16'h0000, 0, 0);
        end
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 5000) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule